// File: doc/BRIEF.md
# Label-Seeking Predicated Instruction Sequencer

This block runs a small memory-to-memory machine that has no program counter. Each instruction says "if the condition holds, write Mdst with Msrcj OP Msrck". The sequencer takes one word from an instruction stream, reads both source operands into latches, drives an external bit-serial ALU for one phase per data bit, writes the result back, then spends one idle phase before it fetches again. A condition code chosen from eight, tested against the zero and negative flags of the last result, predicates every instruction.

Control flow happens by writing to a reserved destination address, the jump port (default 32). A taken write there makes the result byte a search target. The sequencer then drains the stream and throws words away until one carries a label equal to the target. That word is the next one executed. A halt input stops fetching, and each pulse on the step input then lets exactly one more instruction through.

The stream interface is valid/ready. `instr_ready` is asserted only in the fetch phase. While halted it stays low unless a step credit is pending, and while a search is running it stays high for words that do not match. A word is consumed on any cycle where valid and ready are both high. The source must hold the word, its label flag and its label stable while valid is high and ready is low.

Top module: `flow_seq`

## Requirements
- R1: After reset the phase output is 0, both flags are 0, and no memory write is driven.
- R2: An instruction word is {cond[23:21], op[20:18], dst[17:12], srcj[11:6], srck[5:0]}. An executed instruction runs through phases 0 to 12 in order, one cycle each except phase 0. With the stream continuously valid and not halted, consecutive instructions are accepted exactly 13 cycles apart.
- R3: The memory address is srcj in phase 1 and srck in phase 2. The values read there appear on `alu_a` and `alu_b` from phase 3 onward.
- R4: `alu_step` is high in phases 3 to 10 only, for exactly 8 cycles per instruction, with `alu_bit` counting 0 to 7. `alu_result` is captured at the end of phase 10.
- R5: In phase 11 a taken instruction whose dst has bit 5 clear writes the captured result to dst. No write occurs in any other phase.
- R6: Condition codes are 0 never, 1 always, 2 zero, 3 nonzero, 4 negative, 5 negative-or-zero, 6 zero-or-positive, 7 positive (neither zero nor negative). They are evaluated on the flags present at fetch.
- R7: An instruction whose condition is false writes nothing, leaves both flags unchanged and still runs the full phase sequence before the next fetch.
- R8: A taken instruction sets the zero flag to (result == 0) and the negative flag to result bit 7 at the end of phase 11. The flags are stable at every other edge.
- R9: A taken instruction with dst equal to 32 writes no memory and starts a search for label = result. Unlabelled words never match, even if their label field equals the target. The first matching word executes, and later words run in order.
- R10: While `halt` is high, no instruction is fetched unless a `step` pulse has been seen. Each pulse admits exactly one instruction.
- R11: With `instr_valid` low, the block stays in phase 0 with `instr_ready` high (not halted, not searching). `instr_ready` is never high outside phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Stream word available |
| instr_ready | output | 1 | Sequencer takes the word this cycle |
| instr_word | input | 24 | Instruction word |
| instr_has_label | input | 1 | Word carries a label |
| instr_label | input | 8 | Label value |
| mem_addr | output | 6 | Operand memory address |
| mem_rd_en | output | 1 | Read strobe (phases 1, 2) |
| mem_rdata | input | 8 | Read data, combinational |
| mem_wr_en | output | 1 | Write strobe (phase 11) |
| mem_wdata | output | 8 | Write data |
| alu_op | output | 3 | Operation field of current instruction |
| alu_a | output | 8 | Operand latch 0 |
| alu_b | output | 8 | Operand latch 1 |
| alu_step | output | 1 | ALU clock enable |
| alu_bit | output | 3 | Bit index of the current ALU step |
| alu_result | input | 8 | ALU result byte |
| halt | input | 1 | Stop fetching |
| step | input | 1 | Admit one instruction while halted |
| flag_zero | output | 1 | Last taken result was zero |
| flag_neg | output | 1 | Last taken result had bit 7 set |
| phase_o | output | 4 | Current phase |

## Verification
Add and subtract programs with a positive and a negative result check the operand routing, the write-back and the spacing of the handshakes. All eight condition codes are tried after a setter instruction that leaves the flags zero, negative or positive. The 24 outcomes tell each code's predicate apart from the others, and the marker locations that were not written show that false predicates are suppressed. The jump program places an unlabelled word whose label field equals the target, a wrongly labelled word and two duplicates ahead in the stream. It separates "skip until the first true match" from comparing the label field alone or taking the last match. The halt, step and starved-stream runs show that fetch is gated by the step credit and waits for valid without moving off phase 0.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int ADDR_W  = 6;
  localparam int CC_W    = 3;
  localparam int OP_W    = 3;
  localparam int INSTR_W = CC_W + OP_W + 3 * ADDR_W;

  typedef enum logic [CC_W-1:0] {
    CC_NEVER  = 3'd0,
    CC_ALWAYS = 3'd1,
    CC_ZERO   = 3'd2,
    CC_NZ     = 3'd3,
    CC_NEG    = 3'd4,
    CC_LE     = 3'd5,
    CC_GE     = 3'd6,
    CC_POS    = 3'd7
  } cc_e;

  typedef struct packed {
    cc_e               cc;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] srcj;
    logic [ADDR_W-1:0] srck;
  } instr_t;
endpackage

// File: rtl/flow_phase_ctr.sv
module flow_phase_ctr #(
  parameter int NPH  = 13,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NPH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == '0) begin
      if (start) phase <= PH_W'(1);
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
  import flow_pkg::*;
(
  input  cc_e  cc,
  input  logic zf,
  input  logic nf,
  output logic ok
);
  always_comb begin
    unique case (cc)
      CC_NEVER:  ok = 1'b0;
      CC_ALWAYS: ok = 1'b1;
      CC_ZERO:   ok = zf;
      CC_NZ:     ok = !zf;
      CC_NEG:    ok = nf;
      CC_LE:     ok = nf | zf;
      CC_GE:     ok = !nf;
      CC_POS:    ok = !nf & !zf;
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/flow_label_cmp.sv
module flow_label_cmp #(
  parameter int LBL_W = 8
) (
  input  logic             has_label,
  input  logic [LBL_W-1:0] label,
  input  logic [LBL_W-1:0] target,
  output logic             hit
);
  assign hit = has_label && (label == target);
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] JUMP_ADDR = 6'd32,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int NPH   = DATA_W + 5,
  localparam int PH_W  = $clog2(NPH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               instr_has_label,
  input  logic [DATA_W-1:0]  instr_label,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd_en,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_wr_en,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [OP_W-1:0]    alu_op,
  output logic [DATA_W-1:0]  alu_a,
  output logic [DATA_W-1:0]  alu_b,
  output logic               alu_step,
  output logic [BIT_W-1:0]   alu_bit,
  input  logic [DATA_W-1:0]  alu_result,
  input  logic               halt,
  input  logic               step,
  output logic               flag_zero,
  output logic               flag_neg,
  output logic [PH_W-1:0]    phase_o
);
  localparam logic [PH_W-1:0] PH_FETCH = '0;
  localparam logic [PH_W-1:0] PH_RDJ   = PH_W'(1);
  localparam logic [PH_W-1:0] PH_RDK   = PH_W'(2);
  localparam logic [PH_W-1:0] PH_ALU0  = PH_W'(3);
  localparam logic [PH_W-1:0] PH_ALUN  = PH_W'(3 + DATA_W - 1);
  localparam logic [PH_W-1:0] PH_WB    = PH_W'(3 + DATA_W);

  instr_t              ir;
  logic                taken;
  logic                seeking;
  logic [DATA_W-1:0]   seek_tgt;
  logic                credit;
  logic [DATA_W-1:0]   res_q;
  logic                hit;
  logic                cond_now;
  logic                allow;
  logic                accept;
  logic                launch;
  logic [PH_W-1:0]     phase;
  instr_t              in_w;

  assign in_w = instr_t'(instr_word);

  flow_label_cmp #(.LBL_W(DATA_W)) u_cmp (
    .has_label (instr_has_label),
    .label     (instr_label),
    .target    (seek_tgt),
    .hit       (hit)
  );

  flow_cond_eval u_cond (
    .cc (in_w.cc),
    .zf (flag_zero),
    .nf (flag_neg),
    .ok (cond_now)
  );

  assign allow       = !halt || credit;
  assign instr_ready = (phase == PH_FETCH) && (seeking ? (!hit || allow) : allow);
  assign accept      = instr_valid && instr_ready;
  assign launch      = accept && (!seeking || hit);

  flow_phase_ctr #(.NPH(NPH), .PH_W(PH_W)) u_ph (
    .clk   (clk),
    .rst_n (rst_n),
    .start (launch),
    .phase (phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir        <= '0;
      taken     <= 1'b0;
      seeking   <= 1'b0;
      seek_tgt  <= '0;
      credit    <= 1'b0;
      alu_a     <= '0;
      alu_b     <= '0;
      res_q     <= '0;
      flag_zero <= 1'b0;
      flag_neg  <= 1'b0;
    end else begin
      if (halt && step)  credit <= 1'b1;
      else if (launch)   credit <= 1'b0;

      if (launch) begin
        ir      <= in_w;
        taken   <= cond_now;
        seeking <= 1'b0;
      end

      if (phase == PH_RDJ) alu_a <= mem_rdata;
      if (phase == PH_RDK) alu_b <= mem_rdata;
      if (phase == PH_ALUN) res_q <= alu_result;

      if (phase == PH_WB && taken) begin
        flag_zero <= (res_q == '0);
        flag_neg  <= res_q[DATA_W-1];
        if (ir.dst == JUMP_ADDR) begin
          seeking  <= 1'b1;
          seek_tgt <= res_q;
        end
      end
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_rd_en = 1'b0;
    unique case (phase)
      PH_RDJ: begin mem_addr = ir.srcj; mem_rd_en = 1'b1; end
      PH_RDK: begin mem_addr = ir.srck; mem_rd_en = 1'b1; end
      PH_WB:  mem_addr = ir.dst;
      default: ;
    endcase
  end

  assign mem_wr_en = (phase == PH_WB) && taken && !ir.dst[ADDR_W-1];
  assign mem_wdata = res_q;
  assign alu_op    = ir.op;
  assign alu_step  = (phase >= PH_ALU0) && (phase <= PH_ALUN);
  assign alu_bit   = BIT_W'(phase - PH_ALU0);
  assign phase_o   = phase;
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
  parameter int DATA_W = 8,
  parameter int PH_W   = 4,
  parameter int AW     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_ready,
  input logic            mem_wr_en,
  input logic [AW-1:0]   mem_addr,
  input logic            alu_step,
  input logic            flag_zero,
  input logic            flag_neg,
  input logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] WB_PH   = PH_W'(DATA_W + 3);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(DATA_W + 4);
  localparam logic [PH_W-1:0] A0_PH   = PH_W'(3);
  localparam logic [PH_W-1:0] AN_PH   = PH_W'(DATA_W + 2);

  // R2
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != '0 && phase_o != LAST_PH) |=> (phase_o == $past(phase_o) + PH_W'(1)));

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == LAST_PH) |=> (phase_o == '0));

  // R11
  ready_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> (phase_o == '0));

  // R5
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (phase_o == WB_PH && !mem_addr[AW-1]));

  // R4
  alu_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_step |-> (phase_o >= A0_PH && phase_o <= AN_PH));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != WB_PH) |=> $stable({flag_zero, flag_neg}));
endmodule

bind flow_seq flow_seq_chk #(.DATA_W(DATA_W), .PH_W(PH_W), .AW(6)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .mem_wr_en   (mem_wr_en),
  .mem_addr    (mem_addr),
  .alu_step    (alu_step),
  .flag_zero   (flag_zero),
  .flag_neg    (flag_neg),
  .phase_o     (phase_o)
);

// File: tb/flow_seq_tb_top.sv
module flow_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid;
  logic        instr_ready;
  logic [23:0] instr_word;
  logic        instr_has_label;
  logic [7:0]  instr_label;
  logic [5:0]  mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic [2:0]  alu_op;
  logic [7:0]  alu_a;
  logic [7:0]  alu_b;
  logic        alu_step;
  logic [2:0]  alu_bit;
  logic [7:0]  alu_result;
  logic        halt = 1'b0;
  logic        step = 1'b0;
  logic        flag_zero;
  logic        flag_neg;
  logic [3:0]  phase_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .instr_has_label(instr_has_label), .instr_label(instr_label),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_step(alu_step),
    .alu_bit(alu_bit), .alu_result(alu_result),
    .halt(halt), .step(step), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .phase_o(phase_o)
  );

  // stream FIFO
  logic [23:0] fw [0:255];
  logic        fh [0:255];
  logic [7:0]  fl [0:255];
  int wr_ptr = 0;
  int rd_ptr = 0;
  assign instr_valid     = (rd_ptr < wr_ptr);
  assign instr_word      = fw[rd_ptr[7:0]];
  assign instr_has_label = fh[rd_ptr[7:0]];
  assign instr_label     = fl[rd_ptr[7:0]];

  // data memory and constants
  logic [7:0] mem [0:31];
  always_comb begin
    if (!mem_addr[5])      mem_rdata = mem[mem_addr[4:0]];
    else if (!mem_addr[4]) mem_rdata = {4'h0, mem_addr[3:0]};
    else                   mem_rdata = {mem_addr[3:0], 4'h0};
  end

  always_comb begin
    case (alu_op)
      3'd0: alu_result = alu_a + alu_b;
      3'd1: alu_result = alu_a - alu_b;
      3'd2: alu_result = alu_a & alu_b;
      3'd3: alu_result = alu_a | alu_b;
      3'd4: alu_result = alu_a ^ alu_b;
      default: alu_result = alu_a;
    endcase
  end

  int cyc = 0;
  int hs_prev = 0;
  int hs_last = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int a = 0; a < 32; a++) mem[a] <= 8'h00;
    end else begin
      if (mem_wr_en) mem[mem_addr[4:0]] <= mem_wdata;
      if (instr_valid && instr_ready) begin
        rd_ptr  <= rd_ptr + 1;
        hs_prev <= hs_last;
        hs_last <= cyc;
      end
    end
  end

  // observation monitor
  logic [5:0] cap_j, cap_k, cap_wa;
  logic [7:0] cap_a, cap_b, cap_wd;
  int alu_cnt = 0;
  int bit_err = 0;
  always @(negedge clk) begin
    if (phase_o == 4'd1) begin cap_j <= mem_addr; alu_cnt <= 0; bit_err <= 0; end
    if (phase_o == 4'd2) cap_k <= mem_addr;
    if (phase_o == 4'd3) begin cap_a <= alu_a; cap_b <= alu_b; end
    if (mem_wr_en) begin cap_wa <= mem_addr; cap_wd <= mem_wdata; end
    if (alu_step) begin
      alu_cnt <= alu_cnt + 1;
      if (int'(alu_bit) != alu_cnt) bit_err <= bit_err + 1;
    end
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input int c, input int op, input int d, input int j, input int k);
    return {c[2:0], op[2:0], d[5:0], j[5:0], k[5:0]};
  endfunction

  task automatic push(input logic [23:0] w, input bit h, input int lab);
    fw[wr_ptr[7:0]] = w;
    fh[wr_ptr[7:0]] = h;
    fl[wr_ptr[7:0]] = lab[7:0];
    wr_ptr = wr_ptr + 1;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (rd_ptr == wr_ptr && phase_o == 4'd0) break;
    end
    @(negedge clk);
  endtask

  function automatic bit exp_cc(input int c, input bit z, input bit n);
    case (c)
      0: return 1'b0;
      1: return 1'b1;
      2: return z;
      3: return !z;
      4: return n;
      5: return n | z;
      6: return !n;
      default: return !n && !z;
    endcase
  endfunction

  task automatic t_reset();
    chk(phase_o == 4'd0, "R1 phase", phase_o, 0);
    chk(!flag_zero && !flag_neg, "R1 flags", {flag_zero, flag_neg}, 0);
    chk(!mem_wr_en, "R1 wr", mem_wr_en, 0);
  endtask

  task automatic t_basic();
    push(mk(1, 3, 3, 38, 32), 0, 0);   // M3 = 6
    push(mk(1, 3, 4, 41, 32), 0, 0);   // M4 = 9
    push(mk(1, 0, 2, 3, 4), 0, 0);     // M2 = 15
    wait_idle();
    chk(mem[2] == 8'd15, "R5 add result", mem[2], 15);
    chk(hs_last - hs_prev == 13, "R2 fetch spacing", hs_last - hs_prev, 13);
    chk(cap_j == 6'd3 && cap_k == 6'd4, "R3 source addrs", {cap_j, cap_k}, {6'd3, 6'd4});
    chk(cap_a == 8'd6 && cap_b == 8'd9, "R3 operand latches", {cap_a, cap_b}, {8'd6, 8'd9});
    chk(alu_cnt == 8 && bit_err == 0, "R4 alu steps", alu_cnt * 100 + bit_err, 800);
    chk(cap_wa == 6'd2 && cap_wd == 8'd15, "R5 write port", {cap_wa, cap_wd}, {6'd2, 8'd15});
    chk(!flag_zero && !flag_neg, "R8 flags positive", {flag_zero, flag_neg}, 0);
    push(mk(1, 1, 5, 3, 4), 0, 0);     // M5 = 6 - 9 = 0xFD
    wait_idle();
    chk(mem[5] == 8'hFD, "R5 sub result", mem[5], 253);
    chk(flag_neg && !flag_zero, "R8 flags negative", {flag_zero, flag_neg}, 1);
  endtask

  task automatic t_never();
    push(mk(1, 3, 11, 39, 32), 0, 0);  // M11 = 7, flags positive
    push(mk(0, 0, 11, 32, 32), 0, 0);  // never: M11 = 0
    push(mk(1, 3, 12, 34, 32), 0, 0);  // M12 = 2
    wait_idle();
    chk(mem[11] == 8'd7, "R7 no write", mem[11], 7);
    chk(mem[12] == 8'd2, "R7 sequence continues", mem[12], 2);
    chk(hs_last - hs_prev == 13, "R7 full phases", hs_last - hs_prev, 13);
    push(mk(1, 3, 11, 39, 32), 0, 0);  // flags positive
    push(mk(0, 1, 11, 32, 33), 0, 0);  // never: would give negative
    wait_idle();
    chk(!flag_zero && !flag_neg, "R7 flags kept", {flag_zero, flag_neg}, 0);
  endtask

  task automatic t_cond(input int s);
    bit ez, en;
    logic [23:0] setter;
    ez = (s == 0);
    en = (s == 1);
    setter = (s == 0) ? mk(1, 0, 10, 32, 32) : (s == 1) ? mk(1, 1, 10, 32, 33) : mk(1, 0, 10, 33, 32);
    for (int c = 0; c < 8; c++) push(mk(1, 3, 20 + c, 32, 32), 0, 0);
    for (int c = 0; c < 8; c++) begin
      push(setter, 0, 0);
      push(mk(c, 3, 20 + c, 33, 32), 0, 0);
    end
    wait_idle();
    for (int c = 0; c < 8; c++) begin
      int e;
      e = exp_cc(c, ez, en) ? 1 : 0;
      chk(int'(mem[20 + c]) == e, $sformatf("R6 code %0d state %0d", c, s), mem[20 + c], e);
    end
  endtask

  task automatic t_jump();
    for (int a = 12; a < 19; a++) push(mk(1, 3, a, 32, 32), 0, 0);
    push(mk(1, 3, 32, 37, 32), 0, 0);  // jump to label 5
    push(mk(1, 3, 12, 33, 32), 0, 5);  // unlabelled, field 5
    push(mk(1, 3, 13, 33, 32), 1, 3);  // wrong label
    push(mk(1, 3, 14, 33, 32), 1, 5);  // first match
    push(mk(1, 3, 15, 33, 32), 1, 5);  // duplicate, runs in order
    wait_idle();
    chk(mem[12] == 0, "R9 unlabelled skipped", mem[12], 0);
    chk(mem[13] == 0, "R9 wrong label skipped", mem[13], 0);
    chk(mem[14] == 1, "R9 first match runs", mem[14], 1);
    chk(mem[15] == 1, "R9 next word runs", mem[15], 1);
    push(mk(0, 3, 32, 37, 32), 0, 0);  // untaken jump
    push(mk(1, 3, 18, 33, 32), 0, 0);
    wait_idle();
    chk(mem[18] == 1, "R9 R7 untaken jump", mem[18], 1);
  endtask

  task automatic t_halt();
    push(mk(1, 3, 16, 32, 32), 0, 0);
    push(mk(1, 3, 17, 32, 32), 0, 0);
    wait_idle();
    halt = 1'b1;
    push(mk(1, 3, 16, 35, 32), 0, 0);
    push(mk(1, 3, 17, 36, 32), 0, 0);
    repeat (30) @(negedge clk);
    chk(mem[16] == 0 && phase_o == 0, "R10 halted", mem[16], 0);
    step = 1'b1; @(negedge clk); step = 1'b0;
    repeat (30) @(negedge clk);
    chk(mem[16] == 3, "R10 one step", mem[16], 3);
    chk(mem[17] == 0, "R10 only one", mem[17], 0);
    step = 1'b1; @(negedge clk); step = 1'b0;
    repeat (30) @(negedge clk);
    chk(mem[17] == 4, "R10 second step", mem[17], 4);
    halt = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_starve();
    int bad;
    bad = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (phase_o != 0 || !instr_ready) bad++;
    end
    chk(bad == 0, "R11 starved wait", bad, 0);
    push(mk(1, 3, 19, 42, 32), 0, 0);
    wait_idle();
    chk(mem[19] == 8'd10, "R11 resumes", mem[19], 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_never();
    for (int s = 0; s < 3; s++) t_cond(s);
    t_jump();
    t_halt();
    t_starve();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R2 actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule